// File: doc/BRIEF.md
# Windowed Key-Sequence Watchdog

This block is a watchdog timer that software keeps quiet by writing a two-byte key to a service register. Each write is checked for its value, for the order of the key bytes and, when window mode is selected, for the point in the period at which it lands. Any fault in servicing, including letting the period run out, produces a one-cycle reset request. The owner of the chip reset uses that request to restart the system.

A free-running counter measures the cycles since the last restart. A period select chooses one of four timeout lengths. Software first writes 0x55 to arm the sequence and then writes 0xAA to complete it. Any number of unrelated cycles may pass between the two writes. Only the completing 0xAA write restarts the count. In window mode, writes are legal only in the last quarter of the selected period.

Top module: `keyed_watchdog`

## Requirements
- R1: While `rst` is high, and after it is released with `en` low, `rst_req` stays 0.
- R2: A write of 0x55 followed later by a write of 0xAA restarts the count and raises no request. Idle cycles between the two writes are allowed. A restart is not caused by the 0x55 write alone.
- R3: A write to the service register with any value other than 0x55 or 0xAA raises `rst_req` in the cycle after the write is sampled.
- R4: A write of 0xAA with no 0x55 pending is an order fault and raises `rst_req`. A second 0x55 while one is already pending keeps it pending and is not a fault.
- R5: `period_sel` value s sets a period of 2^(10+2s) cycles: 0 gives 1024, 1 gives 4096, 2 gives 16384 and 3 gives 65536. If no valid pair completes, `rst_req` rises exactly one period after the last restart edge.
- R6: With `win_mode` high, a key write sampled while the count is below three quarters of the period is premature and raises `rst_req`. A write sampled at a count of three quarters or more is accepted. For the 1024-cycle period the first legal count is 768.
- R7: With `en` low, no request is raised, writes are ignored, and the counter and pending flag are held clear. After re-enabling, a full period elapses before any timeout.
- R8: `rst_req` is high for one cycle only. A fault clears the counter and the pending 0x55. Writes sampled while `rst_req` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Watchdog enable |
| win_mode | input | 1 | Restrict key writes to the last quarter of the period |
| period_sel | input | 2 | Timeout length select |
| wr_stb | input | 1 | Service-register write strobe |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | Registered one-cycle reset request |

## Verification
A faulting write sampled at edge k shows `rst_req` high from edge k onward. The bench therefore expects the pulse in the cycle numbered k. A timeout pulse is due exactly one period of edges after the edge that last cleared the counter. The bench keeps its own model of that restart edge, of the pending flag and of the window boundary. From that model the driver predicts the cycle of every pulse and pushes it into a queue. A monitor samples on falling edges and matches each observed pulse against the queue head by cycle number. It flags unexpected pulses, and it flags expected pulses whose cycle passes without one.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;

  typedef enum logic [2:0] {
    FLT_NONE,
    FLT_VALUE,
    FLT_ORDER,
    FLT_EARLY,
    FLT_EXPIRE
  } fault_e;

  function automatic int period_shift(input int base_log2, input int step_log2, input int idx);
    return base_log2 + step_log2 * idx;
  endfunction

endpackage

// File: rtl/wdg_period_cnt.sv
module wdg_period_cnt #(
  parameter int NUM_PERIODS = 4,
  parameter int BASE_LOG2   = 10,
  parameter int STEP_LOG2   = 2,
  parameter int SEL_W       = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             expire_o,
  output logic             win_open_o
);
  import wdg_pkg::*;

  logic [CNT_W:0]   lim_tbl [NUM_PERIODS];
  logic [CNT_W:0]   lim_sel;
  logic [CNT_W:0]   win_start;
  logic [CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_lim
    localparam int SH = period_shift(BASE_LOG2, STEP_LOG2, g);
    assign lim_tbl[g] = {{CNT_W{1'b0}}, 1'b1} << SH;
  end

  assign lim_sel   = lim_tbl[sel_i];
  assign win_start = lim_sel - (lim_sel >> 2);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o   = en_i && ({1'b0, cnt_q} >= (lim_sel - 1'b1));
  assign win_open_o = ({1'b0, cnt_q} >= win_start);

  // R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (rst)
    en_i && restart_i |=> cnt_q == '0);

  // R7
  cnt_held_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> cnt_q == '0);

endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_i,
  input  logic           win_en_i,
  input  logic           hold_i,
  input  logic           wr_i,
  input  logic [7:0]     data_i,
  input  logic           win_open_i,
  input  logic           expire_i,
  output wdg_pkg::fault_e kind_o,
  output logic           serviced_o
);
  import wdg_pkg::*;

  logic pend_q;
  logic take;
  logic is_arm;
  logic is_fire;
  logic early;

  assign take    = en_i && wr_i && !hold_i;
  assign is_arm  = (data_i == KEY_ARM);
  assign is_fire = (data_i == KEY_FIRE);
  assign early   = win_en_i && !win_open_i;

  always_comb begin
    kind_o     = FLT_NONE;
    serviced_o = 1'b0;
    if (take) begin
      if (!is_arm && !is_fire) begin
        kind_o = FLT_VALUE;
      end else if (early) begin
        kind_o = FLT_EARLY;
      end else if (is_fire && !pend_q) begin
        kind_o = FLT_ORDER;
      end else if (is_fire) begin
        serviced_o = 1'b1;
      end
    end
    if (kind_o == FLT_NONE && !serviced_o && en_i && !hold_i && expire_i) begin
      kind_o = FLT_EXPIRE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      pend_q <= 1'b0;
    end else if (kind_o != FLT_NONE || serviced_o) begin
      pend_q <= 1'b0;
    end else if (take && is_arm) begin
      pend_q <= 1'b1;
    end
  end

  // R2
  svc_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    serviced_o |-> pend_q);

  // R4
  arm_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    take && is_arm && kind_o == FLT_NONE |=> pend_q);

  // R8
  fault_clears_pend_chk: assert property (@(posedge clk) disable iff (rst)
    kind_o != FLT_NONE |=> !pend_q);

endmodule

// File: rtl/wdg_req_out.sv
module wdg_req_out (
  input  logic            clk,
  input  logic            rst,
  input  wdg_pkg::fault_e kind_i,
  output logic            req_o
);
  import wdg_pkg::*;

  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= (kind_i != FLT_NONE);
    end
  end

  assign req_o = req_q;

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    req_q |=> !req_q);

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int NUM_PERIODS = 4,
  parameter int BASE_LOG2   = 10,
  parameter int STEP_LOG2   = 2,
  localparam int SEL_W      = $clog2(NUM_PERIODS),
  localparam int CNT_W      = BASE_LOG2 + STEP_LOG2 * (NUM_PERIODS - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             win_mode,
  input  logic [SEL_W-1:0] period_sel,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  output logic             rst_req
);
  import wdg_pkg::*;

  logic   expire;
  logic   win_open;
  logic   serviced;
  logic   restart;
  fault_e kind;

  assign restart = serviced || (kind != FLT_NONE);

  wdg_period_cnt #(
    .NUM_PERIODS(NUM_PERIODS),
    .BASE_LOG2  (BASE_LOG2),
    .STEP_LOG2  (STEP_LOG2),
    .SEL_W      (SEL_W),
    .CNT_W      (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en),
    .sel_i     (period_sel),
    .restart_i (restart),
    .expire_o  (expire),
    .win_open_o(win_open)
  );

  wdg_key_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en),
    .win_en_i  (win_mode),
    .hold_i    (rst_req),
    .wr_i      (wr_stb),
    .data_i    (wr_data),
    .win_open_i(win_open),
    .expire_i  (expire),
    .kind_o    (kind),
    .serviced_o(serviced)
  );

  wdg_req_out u_out (
    .clk   (clk),
    .rst   (rst),
    .kind_i(kind),
    .req_o (rst_req)
  );

  // R3
  bad_value_req_chk: assert property (@(posedge clk) disable iff (rst)
    en && wr_stb && !rst_req && wr_data != KEY_ARM && wr_data != KEY_FIRE |=> rst_req);

  // R6
  early_write_req_chk: assert property (@(posedge clk) disable iff (rst)
    en && wr_stb && !rst_req && win_mode && !win_open |=> rst_req);

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !rst_req);

  // R5
  expire_restarts_chk: assert property (@(posedge clk) disable iff (rst)
    expire && !rst_req |-> restart);

endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic       win_mode;
  logic [1:0] period_sel;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       rst_req;

  always #10 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .win_mode  (win_mode),
    .period_sel(period_sel),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rst_req   (rst_req)
  );

  typedef struct {
    int    at;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   compared = 0;
  int   mismatched = 0;
  int   pulses = 0;
  bit   done = 0;

  int   base = 0;
  int   last_pulse = -10;
  int   per = 1024;
  bit   pend = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (q.size() > 0 && q[0].at < cyc) begin
        compared++;
        mismatched++;
        $display("FAIL %s: rst_req missing at cycle %0d, actual 0 expected 1", q[0].tag, q[0].at);
        void'(q.pop_front());
      end
      if (rst_req) begin
        pulses++;
        compared++;
        if (q.size() > 0 && q[0].at == cyc) begin
          void'(q.pop_front());
        end else begin
          mismatched++;
          $display("FAIL unexpected rst_req at cycle %0d, actual 1 expected 0", cyc);
        end
      end
    end
  end

  task automatic push(input int at, input string tag);
    exp_t e;
    e.at  = at;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v, input string tag);
    int k;
    int c;
    bit f;
    k = cyc + 1;
    wr_stb  = 1'b1;
    wr_data = v;
    if (en && k != last_pulse + 1) begin
      c = k - 1 - base;
      f = (v != 8'h55 && v != 8'hAA) ||
          (win_mode && c < (per - per / 4)) ||
          (v == 8'hAA && !pend);
      if (f) begin
        push(k, tag);
        base = k;
        last_pulse = k;
        pend = 0;
      end else if (v == 8'hAA) begin
        base = k;
        pend = 0;
      end else begin
        pend = 1;
      end
    end
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_cnt(input int target);
    idle(base + target - cyc);
  endtask

  task automatic run_timeout(input string tag);
    int p;
    p = base + per;
    push(p, tag);
    idle(p - cyc);
    base = p;
    last_pulse = p;
    pend = 0;
  endtask

  task automatic quiet(input int n, input string tag);
    int pc;
    pc = pulses;
    idle(n);
    compared++;
    if (pulses != pc) begin
      mismatched++;
      $display("FAIL %s: %0d pulses in quiet stretch, expected 0", tag, pulses - pc);
    end
  endtask

  task automatic set_en(input bit b);
    en = b;
    pend = 0;
    base = cyc;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      summary();
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; win_mode = 1'b0; period_sel = 2'd0;
    wr_stb = 1'b0; wr_data = 8'h00;
    idle(4);
    compared++;
    if (rst_req !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: rst_req in reset actual %b expected 0", rst_req);
    end
    rst = 1'b0;
    idle(3);
    compared++;
    if (rst_req !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: rst_req after reset actual %b expected 0", rst_req);
    end

    // R2: valid pair with idle cycles between, then timeout from the 0xAA edge (R5)
    set_en(1'b1);
    wait_cnt(300);
    wr(8'h55, "R2");
    idle(40);
    wr(8'hAA, "R2");
    quiet(900, "R2");
    run_timeout("R5");

    // R3: bad value; an immediate second write lands in the pulse cycle (R8)
    idle(10);
    wr(8'h3C, "R3");
    wr(8'h00, "R8");
    quiet(5, "R8");

    // R4: 0xAA with nothing pending, then 0x55 twice before 0xAA
    idle(5);
    wr(8'hAA, "R4");
    idle(5);
    wr(8'h55, "R4");
    wr(8'h55, "R4");
    idle(3);
    wr(8'hAA, "R4");
    quiet(50, "R4");

    // R8: a fault drops the pending 0x55
    wr(8'h55, "R8");
    wr(8'h77, "R3");
    idle(3);
    wr(8'hAA, "R8");

    // R5 and R8: timeout with 0x55 pending clears it
    idle(4);
    wr(8'h55, "R5");
    run_timeout("R5");
    wr(8'hAA, "R8");
    idle(2);
    wr(8'hAA, "R8");

    // R6: window mode, early write, boundary 767 and 768
    win_mode = 1'b1;
    wait_cnt(100);
    wr(8'h55, "R6");
    wait_cnt(767);
    wr(8'h55, "R6");
    wait_cnt(768);
    wr(8'h55, "R6");
    wr(8'hAA, "R6");
    quiet(700, "R6");
    win_mode = 1'b0;

    // R7: disabled, writes ignored; then R5 with the 4096 period
    set_en(1'b0);
    period_sel = 2'd1;
    per = 4096;
    wr(8'h12, "R7");
    quiet(100, "R7");
    set_en(1'b1);
    run_timeout("R5");

    // R7: long disabled stretch, then a full fresh period
    set_en(1'b0);
    wr(8'hAA, "R7");
    wr(8'h01, "R7");
    quiet(5000, "R7");
    period_sel = 2'd0;
    per = 1024;
    set_en(1'b1);
    run_timeout("R7");

    idle(5);
    while (q.size() > 0) begin
      compared++;
      mismatched++;
      $display("FAIL %s: pending pulse at %0d never seen, actual 0 expected 1", q[0].tag, q[0].at);
      void'(q.pop_front());
    end
    done = 1;
    summary();
  end

endmodule